// File: doc/BRIEF.md
# Serial Peripheral Port with Multi-Master Fault Detection

This block is one serial peripheral port. A bit in its control word picks the role. As master, it makes a serial clock that runs only while a word is in flight. It sends the word on the master-out line and collects the word coming back on the master-in line. As slave, it takes the serial clock and an active-low select from outside. It collects data from the master-out line and drives its own word on the master-in line. Clock polarity, clock phase, word length (8, 16 or 32 bits, most significant bit first) and the master clock divider are all fields of the control word. When a word completes, a one-cycle done pulse is raised and the received word is presented, right-justified.

A master must never see its own select go low. If that happens, another device is trying to be master. The port then raises a sticky fault flag, drops the master bit and releases its clock and data drivers. For several slaves on one bus, the slave's master-in driver can be limited to pulling low only, so a pull-up supplies the high level. It can also be switched off completely, so one master can broadcast to many listening slaves.

Top module: `spi_port`

## Requirements
- R1: In master mode the serial clock rests at the polarity bit (control bit 1) whenever no word is in flight. It makes exactly as many full cycles as the word has bits.
- R2: Each master serial clock half-period lasts BAUD+1 system clocks, where BAUD is control bits 15:8.
- R3: Words are shifted most significant bit first. The length code in control bits 7:6 selects 8 bits (0), 16 bits (1) or 32 bits (2 or 3). A master sends the low bits of the transmit word on the master-out line and returns the master-in bits right-justified in the received word.
- R4: With the phase bit (control bit 2) clear, data is sampled on the first clock edge of each bit and changed on the second edge. With the phase bit set, data changes on the first edge and is sampled on the second edge. Both cases hold for either polarity.
- R5: In slave mode (control bit 0 clear) with select low, the port receives on the master-out line and drives its transmit word on the master-in line, most significant bit first.
- R6: While the slave select is high, serial clock edges shift nothing. A slave deselected partway through a word discards the partial bits, and the next word starts again from the most significant bit.
- R7: If the synchronised select input is low while control bit 0 is set, the fault flag is set, control bit 0 is cleared, and the transfer is aborted without a done pulse. Both output enables, for the serial clock and for master-out, drop.
- R8: The fault flag stays set until the fault-clear input is pulsed.
- R9: With control bit 3 set, the slave never drives the master-in line high. It enables its driver only to send a 0.
- R10: With control bit 5 set, the slave never enables its master-in driver. It still receives words.
- R11: Each completed word gives exactly one done pulse, and the received word is valid in the same cycle as that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 16 | Control word write value |
| faultClr | input | 1 | Clears the sticky fault flag |
| ctrlQ | output | 16 | Current control word |
| faultFlag | output | 1 | Sticky multi-master fault |
| txStart | input | 1 | Master: start one word |
| txWord | input | 32 | Word to transmit |
| busy | output | 1 | Master word in flight |
| done | output | 1 | One-cycle word-complete pulse |
| rxWord | output | 32 | Last received word, right-justified |
| sclkI | input | 1 | Serial clock in (slave) |
| sclkO | output | 1 | Serial clock out (master) |
| sclkOe | output | 1 | Serial clock driver enable |
| selN | input | 1 | Active-low device select |
| mosiI | input | 1 | Master-out line in (slave) |
| mosiO | output | 1 | Master-out line drive |
| mosiOe | output | 1 | Master-out driver enable |
| misoI | input | 1 | Master-in line in (master) |
| misoO | output | 1 | Master-in line drive |
| misoOe | output | 1 | Master-in driver enable |

## Verification
A wrong bit counter or edge counter shows up on the first word: the serial clock is left at the wrong level, makes too few or too many cycles, or the done pulse arrives with a shifted received word. The scoreboard compares that word a cycle after the last edge. A wrong shift register or phase choice corrupts the transmitted bits that the bench's own link partner collects during the same word. A fault path that fails to clear its state leaves the drivers enabled or the flag low within a few cycles of the select falling. A slave counter that keeps its state across a deselect misaligns the very next full word.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int CTRL_W      = 16;
  localparam int BAUD_W      = 8;
  localparam int BIT_MASTER  = 0;
  localparam int BIT_CPOL    = 1;
  localparam int BIT_CPHA    = 2;
  localparam int BIT_OD      = 3;
  localparam int BIT_MISODIS = 5;
  localparam int LEN_LO      = 6;
  localparam int BAUD_LO     = 8;

  typedef struct packed {
    logic load;
    logic advance;
    logic sample;
    logic capture;
  } spiStrobes_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2,
  parameter int CNT_W  = $clog2(2 * DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              faultClr,
  input  logic              txStart,
  input  logic              sclkIn,
  input  logic              selNIn,
  input  logic              mosiIn,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              faultFlag,
  output logic              busy,
  output logic              sclkOut,
  output logic              slaveSel,
  output logic              mosiSync,
  output logic [CNT_W-1:0]  wordBits,
  output spiStrobes_t       strb
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [SYNC_N-1:0] sclkS, selS, mosiS;
  logic              sclkPrev, sclkR;
  logic [BAUD_W-1:0] halfCnt;
  logic [CNT_W-1:0]  edgeCnt, slvCnt, lastEdge;
  logic master, cpol, cpha, selLow, faultHit;
  logic halfDone, leading, mSample, mAdvance, mLast, mLoad;
  logic sclkNow, sEdge, sLead, sTrail, slvActive, sSample, sAdvance, sLast;
  logic [BAUD_W-1:0] baud;

  assign master   = ctrlReg[BIT_MASTER];
  assign cpol     = ctrlReg[BIT_CPOL];
  assign cpha     = ctrlReg[BIT_CPHA];
  assign baud     = ctrlReg[BAUD_LO +: BAUD_W];
  assign selLow   = ~selS[SYNC_N-1];
  assign faultHit = master & selLow;

  always_comb begin
    case (ctrlReg[LEN_LO +: 2])
      2'd0:    wordBits = CNT_W'(8);
      2'd1:    wordBits = CNT_W'(16);
      default: wordBits = CNT_W'(DATA_W);
    endcase
  end
  assign lastEdge = (wordBits << 1) - CNT_W'(1);

  // master timing: every half period is one serial clock edge
  assign halfDone = busy & (halfCnt == baud);
  assign leading  = ~edgeCnt[0];
  assign mSample  = halfDone & (cpha ? ~leading : leading);
  assign mAdvance = halfDone & (cpha ? (leading & (edgeCnt != '0))
                                     : (~leading & (edgeCnt != lastEdge)));
  assign mLast    = halfDone & (edgeCnt == lastEdge);
  assign mLoad    = ~busy & txStart & master & ~faultHit;

  // slave timing: edges of the synchronised external clock
  assign sclkNow   = sclkS[SYNC_N-1];
  assign sEdge     = sclkNow ^ sclkPrev;
  assign sLead     = sEdge & (sclkNow != cpol);
  assign sTrail    = sEdge & (sclkNow == cpol);
  assign slvActive = ~master & selLow;
  assign sSample   = slvActive & (cpha ? sTrail : sLead);
  assign sAdvance  = slvActive & (cpha ? sLead : sTrail) & (slvCnt != '0);
  assign sLast     = sSample & (slvCnt == wordBits - CNT_W'(1));

  always_comb begin
    if (master) begin
      strb.load    = mLoad;
      strb.advance = mAdvance & ~faultHit;
      strb.sample  = mSample & ~faultHit;
      strb.capture = mLast & ~faultHit;
    end else begin
      strb.load    = ~slvActive | sLast;
      strb.advance = sAdvance;
      strb.sample  = sSample;
      strb.capture = sLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkS    <= '0;
      selS     <= '1;
      mosiS    <= '0;
      sclkPrev <= 1'b0;
      ctrlReg  <= '0;
      faultFlag <= 1'b0;
      busy     <= 1'b0;
      sclkR    <= 1'b0;
      halfCnt  <= '0;
      edgeCnt  <= '0;
      slvCnt   <= '0;
    end else begin
      sclkS    <= {sclkS[SYNC_N-2:0], sclkIn};
      selS     <= {selS[SYNC_N-2:0], selNIn};
      mosiS    <= {mosiS[SYNC_N-2:0], mosiIn};
      sclkPrev <= sclkNow;

      if (ctrlWe) ctrlReg <= ctrlWdata;
      if (faultClr) faultFlag <= 1'b0;
      if (faultHit) begin
        faultFlag           <= 1'b1;
        ctrlReg[BIT_MASTER] <= 1'b0;
      end

      if (faultHit || !master) begin
        busy    <= 1'b0;
        sclkR   <= cpol;
        halfCnt <= '0;
        edgeCnt <= '0;
      end else if (mLoad) begin
        busy    <= 1'b1;
        sclkR   <= cpol;
        halfCnt <= '0;
        edgeCnt <= '0;
      end else if (busy) begin
        if (halfDone) begin
          halfCnt <= '0;
          sclkR   <= ~sclkR;
          edgeCnt <= edgeCnt + CNT_W'(1);
          if (mLast) busy <= 1'b0;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end else begin
        sclkR <= cpol;
      end

      if (!slvActive) slvCnt <= '0;
      else if (sSample) slvCnt <= sLast ? '0 : slvCnt + CNT_W'(1);
    end
  end

  assign ctrlQ    = ctrlReg;
  assign sclkOut  = sclkR;
  assign slaveSel = selLow;
  assign mosiSync = mosiS[SYNC_N-1];

  a_r1_idle_polarity: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !mLoad) |=> (sclkR == $past(ctrlReg[BIT_CPOL])));
  a_r7_fault_drops_master: assert property (@(posedge clk) disable iff (!rstN)
    faultHit |=> (!ctrlReg[BIT_MASTER] && faultFlag && !busy));
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !faultClr) |=> faultFlag);
  a_r6_deselect_clears: assert property (@(posedge clk) disable iff (!rstN)
    !slvActive |=> (slvCnt == '0));
  a_r11_master_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    (master && strb.capture) |=> !busy);
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(2 * DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strb,
  input  logic [DATA_W-1:0] txWord,
  input  logic [CNT_W-1:0]  wordBits,
  input  logic              rxBit,
  output logic              txBit,
  output logic [DATA_W-1:0] rxWord,
  output logic              done
);
  logic [DATA_W-1:0] txSr, rxSr, rxNext, rxMask;
  int shiftAmt;

  assign shiftAmt = DATA_W - int'(wordBits);
  assign rxMask   = {DATA_W{1'b1}} >> shiftAmt;
  assign rxNext   = strb.sample ? {rxSr[DATA_W-2:0], rxBit} : rxSr;
  assign txBit    = txSr[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr   <= '0;
      rxSr   <= '0;
      rxWord <= '0;
      done   <= 1'b0;
    end else begin
      if (strb.load) txSr <= txWord << shiftAmt;
      else if (strb.advance) txSr <= txSr << 1;
      rxSr <= rxNext;
      done <= strb.capture;
      if (strb.capture) rxWord <= rxNext & rxMask;
    end
  end

  a_r3_load_vs_shift: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.advance);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [15:0]       ctrlWdata,
  input  logic              faultClr,
  output logic [15:0]       ctrlQ,
  output logic              faultFlag,
  input  logic              txStart,
  input  logic [DATA_W-1:0] txWord,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxWord,
  input  logic              sclkI,
  output logic              sclkO,
  output logic              sclkOe,
  input  logic              selN,
  input  logic              mosiI,
  output logic              mosiO,
  output logic              mosiOe,
  input  logic              misoI,
  output logic              misoO,
  output logic              misoOe
);
  localparam int CNT_W = $clog2(2 * DATA_W) + 1;

  spiStrobes_t      strb;
  logic [CNT_W-1:0] wordBits;
  logic slaveSel, mosiSync, txBit, rxBit, master, openDrain, misoDis;

  spi_port_ctrl #(.DATA_W(DATA_W), .SYNC_N(SYNC_N), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .faultClr(faultClr), .txStart(txStart), .sclkIn(sclkI), .selNIn(selN),
    .mosiIn(mosiI), .ctrlQ(ctrlQ), .faultFlag(faultFlag), .busy(busy),
    .sclkOut(sclkO), .slaveSel(slaveSel), .mosiSync(mosiSync),
    .wordBits(wordBits), .strb(strb)
  );

  assign master    = ctrlQ[BIT_MASTER];
  assign openDrain = ctrlQ[BIT_OD];
  assign misoDis   = ctrlQ[BIT_MISODIS];
  assign rxBit     = master ? misoI : mosiSync;

  spi_port_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txWord(txWord),
    .wordBits(wordBits), .rxBit(rxBit), .txBit(txBit),
    .rxWord(rxWord), .done(done)
  );

  assign sclkOe = master;
  assign mosiO  = txBit;
  assign mosiOe = master;
  assign misoO  = openDrain ? 1'b0 : txBit;
  assign misoOe = ~master & slaveSel & ~misoDis & (~openDrain | ~txBit);

  a_r9_od_low_only: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[BIT_OD] && misoOe) |-> !misoO);
  a_r10_miso_disabled: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[BIT_MISODIS] |-> !misoOe);
endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SLV   = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 1'b0, faultClr = 1'b0, txStart = 1'b0;
  logic [15:0] ctrlWdata = '0, ctrlQ;
  logic [31:0] txWord = '0, rxWord;
  logic sclkI = 1'b0, selN = 1'b1, mosiI = 1'b0, misoI = 1'b1;
  logic faultFlag, busy, done, sclkO, sclkOe, mosiO, mosiOe, misoO, misoOe;

  int nChecks = 0, nFail = 0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .faultClr(faultClr), .ctrlQ(ctrlQ), .faultFlag(faultFlag),
    .txStart(txStart), .txWord(txWord), .busy(busy), .done(done),
    .rxWord(rxWord), .sclkI(sclkI), .sclkO(sclkO), .sclkOe(sclkOe),
    .selN(selN), .mosiI(mosiI), .mosiO(mosiO), .mosiOe(mosiOe),
    .misoI(misoI), .misoO(misoO), .misoOe(misoOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lenBits(input logic [1:0] lc);
    return (lc == 2'd0) ? 8 : (lc == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] maskOf(input int bits);
    return (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

  task automatic writeCtrl(input logic [15:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor: every done pulse pops one expected word
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (expQ.size() == 0) begin
          nChecks++; nFail++;
          $display("FAIL R11 unexpected done actual=%0h expected=none", rxWord);
        end else begin
          check("R11 R3 received word", rxWord, expQ.pop_front());
        end
      end
    end
  end

  // master transfer with a bench slave on the far side (R1 R2 R3 R4)
  task automatic masterXfer(input logic [1:0] lc, input logic cpol, input logic cpha,
                            input logic [7:0] baud, input logic [31:0] txw,
                            input logic [31:0] sw);
    int bits;
    logic [31:0] got;
    longint lastT;
    int badGap;
    bits = lenBits(lc); got = '0; badGap = 0; lastT = 0;
    writeCtrl({baud, lc, 2'b00, 1'b0, cpha, cpol, 1'b1});
    txWord = txw;
    misoI  = sw[bits-1];
    expQ.push_back(sw & maskOf(bits));
    fork
      begin
        @(negedge clk); txStart = 1'b1;
        @(negedge clk); txStart = 1'b0;
      end
      begin
        for (int e = 0; e < 2 * bits; e++) begin
          logic lead;
          int k;
          @(sclkO);
          if (e > 0 && ($time - lastT) != longint'((baud + 1) * CLK_PERIOD)) badGap++;
          lastT = $time;
          lead = (e % 2 == 0);
          k = e / 2;
          if (lead != cpha) got = {got[30:0], mosiO};
          if (cpha && lead) misoI = sw[bits-1-k];
          if (!cpha && !lead && k < bits - 1) misoI = sw[bits-2-k];
        end
      end
    join
    repeat (int'(baud) + 4) @(negedge clk);
    check("R1 clock rests at polarity", {31'd0, sclkO}, {31'd0, cpol});
    check("R1 master idle after word", {31'd0, busy}, 32'd0);
    check("R2 half period gaps", badGap, 0);
    check("R3 R4 master-out word", got, txw & maskOf(bits));
  endtask

  task automatic slaveBits(input int n, input logic cpha, input logic cpol,
                           input logic [31:0] mw, input int bits,
                           inout logic [31:0] got, inout logic oeSeen, inout logic highSeen);
    for (int b = 0; b < n; b++) begin
      logic line;
      if (!cpha) begin
        mosiI = mw[bits-1-b];
        repeat (HALF_SLV) @(negedge clk);
        line = misoOe ? misoO : 1'b1;
        oeSeen |= misoOe; highSeen |= (misoOe & misoO & dut_i.ctrlQ[3]);
        got = {got[30:0], line};
        sclkI = ~cpol;
        repeat (HALF_SLV) @(negedge clk);
        sclkI = cpol;
      end else begin
        sclkI = ~cpol;
        mosiI = mw[bits-1-b];
        repeat (HALF_SLV) @(negedge clk);
        line = misoOe ? misoO : 1'b1;
        oeSeen |= misoOe; highSeen |= (misoOe & misoO & ctrlQ[3]);
        got = {got[30:0], line};
        sclkI = cpol;
        repeat (HALF_SLV) @(negedge clk);
      end
    end
  endtask

  // slave transfer with the bench acting as master (R4 R5 R6 R9 R10)
  task automatic slaveXfer(input logic [1:0] lc, input logic cpol, input logic cpha,
                           input logic od, input logic dis,
                           input logic [31:0] mw, input logic [31:0] txw, input int abortBits);
    int bits;
    logic [31:0] got;
    logic oeSeen, highSeen;
    bits = lenBits(lc);
    writeCtrl({8'd0, lc, dis, 1'b0, od, cpha, cpol, 1'b0});
    sclkI = cpol; txWord = txw;
    repeat (4) @(negedge clk);
    got = '0; oeSeen = 1'b0; highSeen = 1'b0;
    if (abortBits > 0) begin
      selN = 1'b0; repeat (4) @(negedge clk);
      slaveBits(abortBits, cpha, cpol, ~mw, bits, got, oeSeen, highSeen);
      selN = 1'b1; repeat (6) @(negedge clk);
      got = '0;
    end
    expQ.push_back(mw & maskOf(bits));
    selN = 1'b0; repeat (4) @(negedge clk);
    slaveBits(bits, cpha, cpol, mw, bits, got, oeSeen, highSeen);
    repeat (HALF_SLV) @(negedge clk);
    selN = 1'b1; repeat (6) @(negedge clk);
    if (dis) begin
      check("R10 master-in driver never enabled", {31'd0, oeSeen}, 32'd0);
    end else begin
      check("R5 R4 R6 slave master-in word", got & maskOf(bits), txw & maskOf(bits));
      if (od) check("R9 no high drive in open-drain", {31'd0, highSeen}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset control word", {16'd0, ctrlQ}, 32'd0);
    check("R7 reset clock driver off", {31'd0, sclkOe}, 32'd0);
    check("R5 reset master-in driver off", {31'd0, misoOe}, 32'd0);
    check("R8 reset fault clear", {31'd0, faultFlag}, 32'd0);

    masterXfer(2'd0, 1'b0, 1'b0, 8'd1, 32'h0000_00A5, 32'h0000_003C);
    masterXfer(2'd1, 1'b1, 1'b1, 8'd0, 32'h0000_BEEF, 32'h0000_1234);
    masterXfer(2'd2, 1'b0, 1'b1, 8'd2, 32'hDEAD_BEEF, 32'h0F1E_2D3C);
    masterXfer(2'd0, 1'b1, 1'b0, 8'd3, 32'h0000_0081, 32'h0000_007E);

    slaveXfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h96, 32'h5A, 0);
    slaveXfer(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hC3A5, 32'h0FF0, 0);
    slaveXfer(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h4B, 32'hD2, 0);
    slaveXfer(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h33, 32'hCC, 0);
    slaveXfer(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA001, 32'h8421, 5);

    // mode fault while a master word is running (R7 R8)
    writeCtrl({8'd3, 2'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1});
    txWord = 32'h1357_9BDF;
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 word in flight before fault", {31'd0, busy}, 32'd1);
    selN = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 fault flag set", {31'd0, faultFlag}, 32'd1);
    check("R7 master bit cleared", {31'd0, ctrlQ[0]}, 32'd0);
    check("R7 drivers released", {30'd0, sclkOe, mosiOe}, 32'd0);
    check("R7 transfer aborted", {31'd0, busy}, 32'd0);
    selN = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 fault flag sticky", {31'd0, faultFlag}, 32'd1);
    faultClr = 1'b1; @(negedge clk); faultClr = 1'b0;
    @(negedge clk);
    check("R8 fault flag cleared", {31'd0, faultFlag}, 32'd0);

    repeat (20) @(negedge clk);
    check("R11 all expected words seen", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule